// File: doc/BRIEF.md
# Debug Address Breakpoint Unit

This unit watches a processor core's memory bus, which carries an address, a read strobe and a write strobe. It raises breakpoint requests for the debug logic. It holds two comparators, and each compares the bus address against its own programmed reference address.

The primary comparator is qualified by a 2-bit access mode. The mode can turn it off, or match it on writes only, on reads only, or on any access. The secondary comparator has a small control word. That word holds an enable bit and a result-invert bit, plus one spare storage bit. With inversion on, the comparator reports every access whose address differs from the reference.

All four registers sit behind a simple 16-bit register port. The per-comparator hits and their combined request are registered. Each one pulses for one clock in the cycle after the bus cycle that caused it. Software is expected to load an address first and then enable its comparator.

Top module: `bkpt_unit`

## Requirements
- R1: With the primary mode field at 00 (register index 1, bits 1:0), `hit0_o` never asserts, whatever the bus does.
- R2: Mode 01 makes the primary comparator match only on cycles with `bus_wr_i` high.
- R3: Mode 10 makes the primary comparator match only on cycles with `bus_rd_i` high.
- R4: Mode 11 makes the primary comparator match on any cycle where `bus_rd_i` or `bus_wr_i` is high.
- R5: A match requires exact equality of `bus_addr_i` with the reference address over all ADDR_W bits. Primary reference is register index 0, secondary is index 2, both read back zero-extended.
- R6: Hit outputs are registered. A qualifying bus cycle raises the output in the next cycle only, and registers are compared with their value before a same-cycle write.
- R7: After reset, all registers read zero and all outputs are low.
- R8: With the secondary enable bit (register index 3, bit 2) at 0, `hit1_o` never asserts.
- R9: With the secondary comparator enabled, `hit1_o` on an access equals the address match, inverted when the invert bit (index 3, bit 1) is 1.
- R10: Register index 3 reads back bits 15:3 as zero. Bit 0 stores and reads back its written value and has no effect on matching.
- R11: A cycle with neither strobe high produces no hit on either comparator, inverted or not.
- R12: `bkpt_req_o` is high in exactly the cycles where `hit0_o` or `hit1_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register index (0 ref0, 1 mode0, 2 ref1, 3 ctl1) |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data of the selected register |
| bus_addr_i | input | ADDR_W | Core memory bus address |
| bus_rd_i | input | 1 | Core read strobe |
| bus_wr_i | input | 1 | Core write strobe |
| hit0_o | output | 1 | Registered primary comparator hit |
| hit1_o | output | 1 | Registered secondary comparator hit |
| bkpt_req_o | output | 1 | Registered combined breakpoint request |

## Verification
The hardest case to reach from the ports is a register write that lands in the same cycle as a bus access. Examples are an address being moved while a comparator is disabled, or being moved under an armed comparator. The bench drives both events together in one cycle. It expects the comparison to use the old register contents and the disabled unit to stay silent. Apart from that case, the bench sweeps every mode, every secondary control value, all four strobe combinations and every address of a 6-bit configuration. For each one it computes the expected hits arithmetically.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  typedef enum logic [1:0] {
    QUAL_OFF = 2'b00,
    QUAL_WR  = 2'b01,
    QUAL_RD  = 2'b10,
    QUAL_ANY = 2'b11
  } qual_e;

  localparam logic [1:0] SEL_REF0 = 2'd0;
  localparam logic [1:0] SEL_MODE0 = 2'd1;
  localparam logic [1:0] SEL_REF1 = 2'd2;
  localparam logic [1:0] SEL_CTL1 = 2'd3;

  typedef struct packed {
    logic en;
    logic inv;
    logic spare;
  } ctl1_t;
endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  output logic [ADDR_W-1:0] ref0_o,
  output qual_e             mode0_o,
  output logic [ADDR_W-1:0] ref1_o,
  output ctl1_t             ctl1_o
);
  localparam int CTL1_W = $bits(ctl1_t);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref0_o  <= '0;
      mode0_o <= QUAL_OFF;
      ref1_o  <= '0;
      ctl1_o  <= '0;
    end else if (we_i) begin
      unique case (sel_i)
        SEL_REF0:  ref0_o  <= wdata_i[ADDR_W-1:0];
        SEL_MODE0: mode0_o <= qual_e'(wdata_i[1:0]);
        SEL_REF1:  ref1_o  <= wdata_i[ADDR_W-1:0];
        default:   ctl1_o  <= ctl1_t'(wdata_i[CTL1_W-1:0]);
      endcase
    end
  end

  always_comb begin
    unique case (sel_i)
      SEL_REF0:  rdata_o = 16'(ref0_o);
      SEL_MODE0: rdata_o = 16'(mode0_o);
      SEL_REF1:  rdata_o = 16'(ref1_o);
      default:   rdata_o = 16'(ctl1_o);
    endcase
  end

  assert_mode_reset_R7: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> mode0_o == QUAL_OFF && !ctl1_o.en);
endmodule

// File: rtl/bkpt_cmp.sv
module bkpt_cmp #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] ref_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              take_rd_i,
  input  logic              take_wr_i,
  input  logic              invert_i,
  output logic              hit_o
);
  logic eq, strobe;

  assign eq     = (addr_i == ref_i);
  assign strobe = (rd_i & take_rd_i) | (wr_i & take_wr_i);
  // inversion applies only to qualified bus cycles
  assign hit_o  = strobe & (eq ^ invert_i);

  always_comb begin
    if (!rd_i && !wr_i) assert_idle_R11: assert (!hit_o);
  end
endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [15:0]       reg_wdata_i,
  output logic [15:0]       reg_rdata_o,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  output logic              hit0_o,
  output logic              hit1_o,
  output logic              bkpt_req_o
);
  logic [ADDR_W-1:0] ref0, ref1;
  qual_e             mode0;
  ctl1_t             ctl1;
  logic              hit0_d, hit1_d;

  bkpt_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .sel_i   (reg_sel_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .ref0_o  (ref0),
    .mode0_o (mode0),
    .ref1_o  (ref1),
    .ctl1_o  (ctl1)
  );

  bkpt_cmp #(.ADDR_W(ADDR_W)) u_cmp0 (
    .addr_i    (bus_addr_i),
    .ref_i     (ref0),
    .rd_i      (bus_rd_i),
    .wr_i      (bus_wr_i),
    .take_rd_i (mode0[1]),
    .take_wr_i (mode0[0]),
    .invert_i  (1'b0),
    .hit_o     (hit0_d)
  );

  bkpt_cmp #(.ADDR_W(ADDR_W)) u_cmp1 (
    .addr_i    (bus_addr_i),
    .ref_i     (ref1),
    .rd_i      (bus_rd_i),
    .wr_i      (bus_wr_i),
    .take_rd_i (ctl1.en),
    .take_wr_i (ctl1.en),
    .invert_i  (ctl1.inv),
    .hit_o     (hit1_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit0_o     <= 1'b0;
      hit1_o     <= 1'b0;
      bkpt_req_o <= 1'b0;
    end else begin
      hit0_o     <= hit0_d;
      hit1_o     <= hit1_d;
      bkpt_req_o <= hit0_d | hit1_d;
    end
  end

  assert_off_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode0 == QUAL_OFF |=> !hit0_o);
  assert_wr_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode0 == QUAL_WR && !bus_wr_i |=> !hit0_o);
  assert_rd_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode0 == QUAL_RD && !bus_rd_i |=> !hit0_o);
  assert_any_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode0 == QUAL_ANY && (bus_rd_i || bus_wr_i) && bus_addr_i == ref0 |=> hit0_o);
  assert_exact_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_addr_i != ref0 |=> !hit0_o);
  assert_en_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl1.en |=> !hit1_o);
  assert_no_strobe_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i && !bus_wr_i |=> !hit0_o && !hit1_o);
  assert_req_sum_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bkpt_req_o == (hit0_o | hit1_o));
  assert_rsvd_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_sel_i == SEL_CTL1 |-> reg_rdata_o[15:3] == '0);
endmodule

// File: tb/bkpt_unit_test.sv
`timescale 1ns/1ps
module bkpt_unit_test;
  localparam int AW = 6;
  localparam logic [AW-1:0] REF0 = 6'h2A;
  localparam logic [AW-1:0] REF1 = 6'h15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [1:0]    sel = 2'd0;
  logic [15:0]   wdata = 16'd0;
  logic [15:0]   rdata;
  logic [AW-1:0] addr = '0;
  logic          rd = 1'b0, wr = 1'b0;
  logic          hit0, hit1, req;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  bkpt_unit #(.ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .bus_addr_i(addr),
    .bus_rd_i(rd), .bus_wr_i(wr), .hit0_o(hit0), .hit1_o(hit1), .bkpt_req_o(req));

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one cycle at negedge, sample 2 ns after the following posedge
  task automatic cycle(logic w, logic [1:0] s, logic [15:0] d,
                       logic [AW-1:0] a, logic r, logic wt);
    @(negedge clk);
    we = w; sel = s; wdata = d; addr = a; rd = r; wr = wt;
    @(posedge clk);
    #2;
    we = 1'b0;
  endtask

  task automatic wreg(logic [1:0] s, logic [15:0] d);
    cycle(1'b1, s, d, '0, 1'b0, 1'b0);
  endtask

  task automatic rreg(string tag, logic [1:0] s, logic [15:0] exp);
    @(negedge clk);
    sel = s;
    #1;
    check(tag, rdata, exp);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R7 reset state
    check("R7 hit0", 16'(hit0), 16'd0);
    check("R7 hit1", 16'(hit1), 16'd0);
    check("R7 req", 16'(req), 16'd0);
    for (int i = 0; i < 4; i++) rreg("R7 regs", 2'(i), 16'd0);

    // R5 readback of references, R10 reserved bits and spare bit
    wreg(2'd0, 16'(REF0));
    wreg(2'd2, 16'(REF1));
    rreg("R5 ref0", 2'd0, 16'(REF0));
    rreg("R5 ref1", 2'd2, 16'(REF1));
    wreg(2'd3, 16'hFFF9);
    rreg("R10 ctl1", 2'd3, 16'h0001);
    wreg(2'd3, 16'h0000);
    rreg("R10 ctl1 clr", 2'd3, 16'h0000);

    // sweep: mode x ctl1 x strobes x address (R1-R4, R5, R8, R9, R10 spare, R11, R12)
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 8; c++) begin
        wreg(2'd1, 16'(m));
        wreg(2'd3, 16'(c));
        for (int b = 0; b < 4; b++) begin
          for (int a = 0; a < (1 << AW); a++) begin
            logic r, w, e0, e1, x0, x1;
            r = b[1]; w = b[0];
            e0 = (AW'(a) == REF0);
            e1 = (AW'(a) == REF1);
            x0 = e0 & ((m[0] & w) | (m[1] & r));
            x1 = c[2] & (r | w) & (e1 ^ c[1]);
            cycle(1'b0, 2'd0, 16'd0, AW'(a), r, w);
            if (m == 0) check("R1 off", 16'(hit0), 16'(x0));
            else if (m == 1) check("R2 wr", 16'(hit0), 16'(x0));
            else if (m == 2) check("R3 rd", 16'(hit0), 16'(x0));
            else check("R4 any", 16'(hit0), 16'(x0));
            if (!c[2]) check("R8 en off", 16'(hit1), 16'(x1));
            else check("R9 inv", 16'(hit1), 16'(x1));
            check("R12 req", 16'(req), 16'(x0 | x1));
          end
        end
        // R11 idle cycle after sweep
        cycle(1'b0, 2'd0, 16'd0, REF0, 1'b0, 1'b0);
        check("R11 idle", 16'({hit0, hit1}), 16'd0);
      end
    end

    // R6 registered one-cycle pulse
    wreg(2'd3, 16'd0);
    wreg(2'd1, 16'd3);
    @(negedge clk);
    addr = REF0; rd = 1'b1;
    #1;
    check("R6 before edge", 16'(hit0), 16'd0);
    @(posedge clk); #2;
    check("R6 pulse", 16'(hit0), 16'd1);
    cycle(1'b0, 2'd0, 16'd0, REF0, 1'b0, 1'b0);
    check("R6 drop", 16'(hit0), 16'd0);

    // R6 write in same cycle as access: old reference applies
    cycle(1'b1, 2'd0, 16'h0011, REF0, 1'b1, 1'b0);
    check("R6 old ref hit", 16'(hit0), 16'd1);
    cycle(1'b0, 2'd0, 16'd0, REF0, 1'b1, 1'b0);
    check("R6 new ref miss", 16'(hit0), 16'd0);
    cycle(1'b0, 2'd0, 16'd0, 6'h11, 1'b1, 1'b0);
    check("R6 new ref hit", 16'(hit0), 16'd1);

    // R1 disabled while reference moves under live traffic
    wreg(2'd1, 16'd0);
    cycle(1'b1, 2'd0, 16'h0005, 6'h05, 1'b1, 1'b1);
    check("R1 moving ref", 16'(req), 16'd0);
    cycle(1'b0, 2'd0, 16'd0, 6'h05, 1'b1, 1'b1);
    check("R1 moved ref", 16'(req), 16'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule